// File: doc/BRIEF.md
# Exclusive Crosspoint Route Switch

This block joins N source ports to N destination ports for serial PCM traffic. Each port has one line into the switch and one line out of it. A route from a source to a destination carries traffic both ways. The source's transmit line drives the destination's output. The destination's receive line returns to the source. One source may feed several destinations. A destination belongs to at most one source at a time.

Route changes arrive as connect or disconnect commands on a small command interface. Each command is held in a single pending slot. It is judged against the route table only in a cycle where the surrounding system marks a safe point. At that edge only the select of the addressed destination changes. All switched outputs are registered, so a live route sees no glitch while another route is added or removed. A response pulse then reports success or rejection. A combinational read port returns the owner of any destination.

Top module: `xpt_crosspoint`

## Requirements
- R1: After reset the table holds no route. Every dst_tx_o and src_rx_o bit reads the idle level 1, cmd_ready is 1 and resp_valid is 0.
- R2: A command is taken on a clock edge where cmd_valid and cmd_ready are both 1. cmd_ready then stays 0 until the edge that applies that command.
- R3: A pending command is applied only on an edge where safe_pt is 1, and never on the edge that captures it. The table does not change on any other edge.
- R4: A connect command (cmd_op = 1) to a free destination records the source as owner. In the cycle after the applying edge, resp_valid is 1 and resp_err is 0 for exactly one cycle.
- R5: A connect to a destination that already has an owner gives resp_err = 1 and leaves the table unchanged.
- R6: A disconnect command (cmd_op = 0) frees a destination only when the named source owns it. Otherwise it gives resp_err = 1 and leaves the table unchanged.
- R7: A command whose source or destination index is N or more gives resp_err = 1 and leaves the table unchanged.
- R8: dst_tx_o[d] equals src_tx_i[owner] as sampled one edge earlier, using the table as it stood before that edge. A destination with no owner drives 1.
- R9: src_rx_o[s] equals, one edge later, dst_rx_i of the lowest-numbered destination owned by s. A source with no destination receives 1.
- R10: Applying a command changes the output of the addressed destination only. Every other route keeps forwarding across the applying edge.
- R11: rd_owned and rd_src show, combinationally, the current owner state of destination rd_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switch clock, faster than the PCM bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 1 | 1 = connect, 0 = disconnect |
| cmd_src | input | SW | Source index of the command |
| cmd_dst | input | SW | Destination index of the command |
| safe_pt | input | 1 | Marks a cycle where a pending change may be applied |
| cmd_ready | output | 1 | Pending slot empty |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_err | output | 1 | Command was rejected |
| src_tx_i | input | N | Line from each source into the switch |
| src_rx_o | output | N | Return line to each source |
| dst_tx_o | output | N | Forward line to each destination |
| dst_rx_i | input | N | Line from each destination into the switch |
| rd_idx | input | SW | Destination to read back |
| rd_owned | output | 1 | Destination rd_idx has an owner |
| rd_src | output | SW | Owner of destination rd_idx |

## Verification
Two pairs of events can fall in the same cycle. In the first, a command capture coincides with safe_pt. The bench issues a connect with safe_pt already high. It expects the command to stay pending and to take effect only at the next safe point. In the second, a table update coincides with traffic forwarding on other routes. Source and destination lines change every cycle with random data. A behavioural model, evaluated after each edge from the pre-edge table, checks every output each cycle. A disturbed or late live route therefore shows up in the very cycle of the change.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  typedef enum logic {
    XPT_DISC = 1'b0,
    XPT_CONN = 1'b1
  } xpt_op_e;

  localparam logic XPT_IDLE = 1'b1;
endpackage

// File: rtl/xpt_route_table.sv
module xpt_route_table
  import xpt_pkg::*;
#(
  parameter int N  = 3,
  parameter int SW = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic                  cmd_op,
  input  logic [SW-1:0]         cmd_src,
  input  logic [SW-1:0]         cmd_dst,
  input  logic                  safe_pt,
  output logic                  cmd_ready,
  output logic                  resp_valid,
  output logic                  resp_err,
  output logic [N-1:0]          own_vld,
  output logic [N-1:0][SW-1:0]  own_src
);
  logic                 pend_q, pend_d;
  xpt_op_e              op_q, op_d;
  logic [SW-1:0]        ps_q, ps_d, pd_q, pd_d;
  logic [N-1:0]         vld_q, vld_d;
  logic [N-1:0][SW-1:0] src_q, src_d;
  logic                 rv_q, rv_d, re_q, re_d;
  logic                 busy, owned_by_src, range_ok, upd_en;

  always_comb begin
    busy         = 1'b0;
    owned_by_src = 1'b0;
    for (int d = 0; d < N; d++) begin
      if (pd_q == SW'(d)) begin
        busy         = vld_q[d];
        owned_by_src = vld_q[d] && (src_q[d] == ps_q);
      end
    end
    range_ok = (int'(ps_q) < N) && (int'(pd_q) < N);
  end

  always_comb begin
    pend_d = pend_q;
    op_d   = op_q;
    ps_d   = ps_q;
    pd_d   = pd_q;
    vld_d  = vld_q;
    src_d  = src_q;
    rv_d   = 1'b0;
    re_d   = 1'b0;
    if (pend_q) begin
      if (safe_pt) begin
        rv_d   = 1'b1;
        pend_d = 1'b0;
        if (!range_ok) begin
          re_d = 1'b1;
        end else if (op_q == XPT_CONN) begin
          if (busy) begin
            re_d = 1'b1;
          end else begin
            for (int d = 0; d < N; d++) begin
              if (pd_q == SW'(d)) begin
                vld_d[d] = 1'b1;
                src_d[d] = ps_q;
              end
            end
          end
        end else begin
          if (!owned_by_src) begin
            re_d = 1'b1;
          end else begin
            for (int d = 0; d < N; d++) begin
              if (pd_q == SW'(d)) vld_d[d] = 1'b0;
            end
          end
        end
      end
    end else if (cmd_valid) begin
      pend_d = 1'b1;
      op_d   = xpt_op_e'(cmd_op);
      ps_d   = cmd_src;
      pd_d   = cmd_dst;
    end
  end

  assign upd_en = pend_q ? safe_pt : cmd_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      op_q   <= XPT_DISC;
      ps_q   <= '0;
      pd_q   <= '0;
      vld_q  <= '0;
      src_q  <= '0;
      rv_q   <= 1'b0;
      re_q   <= 1'b0;
    end else begin
      rv_q <= rv_d;
      re_q <= re_d;
      if (upd_en) begin
        pend_q <= pend_d;
        op_q   <= op_d;
        ps_q   <= ps_d;
        pd_q   <= pd_d;
        vld_q  <= vld_d;
        src_q  <= src_d;
      end
    end
  end

  assign cmd_ready  = !pend_q;
  assign resp_valid = rv_q;
  assign resp_err   = re_q;
  assign own_vld    = vld_q;
  assign own_src    = src_q;
endmodule

// File: rtl/xpt_fwd_mux.sv
module xpt_fwd_mux
  import xpt_pkg::*;
#(
  parameter int N  = 3,
  parameter int SW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         own_vld,
  input  logic [N-1:0][SW-1:0] own_src,
  input  logic [N-1:0]         src_tx_i,
  output logic [N-1:0]         dst_tx_o
);
  for (genvar gd = 0; gd < N; gd++) begin : g_dst
    logic pick, out_q;
    always_comb begin
      pick = XPT_IDLE;
      if (own_vld[gd]) begin
        for (int s = 0; s < N; s++) begin
          if (own_src[gd] == SW'(s)) pick = src_tx_i[s];
        end
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= XPT_IDLE;
      else        out_q <= pick;
    end
    assign dst_tx_o[gd] = out_q;
  end
endmodule

// File: rtl/xpt_ret_mux.sv
module xpt_ret_mux
  import xpt_pkg::*;
#(
  parameter int N  = 3,
  parameter int SW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         own_vld,
  input  logic [N-1:0][SW-1:0] own_src,
  input  logic [N-1:0]         dst_rx_i,
  output logic [N-1:0]         src_rx_o
);
  for (genvar gs = 0; gs < N; gs++) begin : g_src
    logic pick, out_q;
    always_comb begin
      pick = XPT_IDLE;
      for (int d = N - 1; d >= 0; d--) begin
        if (own_vld[d] && (own_src[d] == SW'(gs))) pick = dst_rx_i[d];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= XPT_IDLE;
      else        out_q <= pick;
    end
    assign src_rx_o[gs] = out_q;
  end
endmodule

// File: rtl/xpt_crosspoint.sv
module xpt_crosspoint #(
  parameter  int N  = 3,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_op,
  input  logic [SW-1:0] cmd_src,
  input  logic [SW-1:0] cmd_dst,
  input  logic          safe_pt,
  output logic          cmd_ready,
  output logic          resp_valid,
  output logic          resp_err,
  input  logic [N-1:0]  src_tx_i,
  output logic [N-1:0]  src_rx_o,
  output logic [N-1:0]  dst_tx_o,
  input  logic [N-1:0]  dst_rx_i,
  input  logic [SW-1:0] rd_idx,
  output logic          rd_owned,
  output logic [SW-1:0] rd_src
);
  logic                 rst_meta, rst_sync_n;
  logic [N-1:0]         own_vld;
  logic [N-1:0][SW-1:0] own_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  xpt_route_table #(.N(N), .SW(SW)) u_table (
    .clk(clk), .rst_n(rst_sync_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_src(cmd_src), .cmd_dst(cmd_dst),
    .safe_pt(safe_pt), .cmd_ready(cmd_ready),
    .resp_valid(resp_valid), .resp_err(resp_err),
    .own_vld(own_vld), .own_src(own_src)
  );

  xpt_fwd_mux #(.N(N), .SW(SW)) u_fwd (
    .clk(clk), .rst_n(rst_sync_n), .own_vld(own_vld), .own_src(own_src),
    .src_tx_i(src_tx_i), .dst_tx_o(dst_tx_o)
  );

  xpt_ret_mux #(.N(N), .SW(SW)) u_ret (
    .clk(clk), .rst_n(rst_sync_n), .own_vld(own_vld), .own_src(own_src),
    .dst_rx_i(dst_rx_i), .src_rx_o(src_rx_o)
  );

  always_comb begin
    rd_owned = 1'b0;
    rd_src   = '0;
    for (int d = 0; d < N; d++) begin
      if (rd_idx == SW'(d)) begin
        rd_owned = own_vld[d];
        rd_src   = own_src[d];
      end
    end
  end
endmodule

// File: rtl/xpt_crosspoint_chk.sv
module xpt_crosspoint_chk #(
  parameter int N  = 3,
  parameter int SW = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic                 cmd_ready,
  input logic                 safe_pt,
  input logic                 resp_valid,
  input logic                 resp_err,
  input logic [N-1:0]         own_vld,
  input logic [N-1:0][SW-1:0] own_src,
  input logic [N-1:0]         dst_tx_o
);
  assert_slot_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  assert_apply_at_safe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(safe_pt));

  assert_table_moves_with_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(own_vld) |-> resp_valid);

  assert_resp_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  assert_reject_keeps_table_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_err) |-> ($stable(own_vld) && $stable(own_src)));

  for (genvar gd = 0; gd < N; gd++) begin : g_idle
    assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(own_vld[gd]) |-> dst_tx_o[gd]);
  end
endmodule

bind xpt_crosspoint xpt_crosspoint_chk #(.N(N), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .safe_pt(safe_pt), .resp_valid(resp_valid), .resp_err(resp_err),
  .own_vld(own_vld), .own_src(own_src), .dst_tx_o(dst_tx_o)
);

// File: tb/xpt_crosspoint_tb.sv
module xpt_crosspoint_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 3;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid, cmd_op, safe_pt;
  logic [SW-1:0] cmd_src, cmd_dst, rd_idx;
  logic          cmd_ready, resp_valid, resp_err, rd_owned;
  logic [SW-1:0] rd_src;
  logic [N-1:0]  src_tx_i, src_rx_o, dst_tx_o, dst_rx_i;

  int checks = 0;
  int failures = 0;

  xpt_crosspoint #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_src(cmd_src), .cmd_dst(cmd_dst), .safe_pt(safe_pt),
    .cmd_ready(cmd_ready), .resp_valid(resp_valid), .resp_err(resp_err),
    .src_tx_i(src_tx_i), .src_rx_o(src_rx_o), .dst_tx_o(dst_tx_o),
    .dst_rx_i(dst_rx_i), .rd_idx(rd_idx), .rd_owned(rd_owned), .rd_src(rd_src)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_own[N];
  bit m_pend, m_op, m_rv, m_re, rs1, rs2, compare_on;
  int m_ps, m_pd;
  bit [N-1:0] m_dtx, m_srx;
  bit got_resp, got_err;

  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      rs1 = 0; rs2 = 0;
    end
    if (!rs2 || !rst_n) begin
      for (int d = 0; d < N; d++) m_own[d] = -1;
      m_pend = 0; m_rv = 0; m_re = 0; m_dtx = '1; m_srx = '1;
    end else begin
      for (int d = 0; d < N; d++)
        m_dtx[d] = (m_own[d] >= 0) ? src_tx_i[m_own[d]] : 1'b1;
      for (int s = 0; s < N; s++) begin
        m_srx[s] = 1'b1;
        for (int d = N - 1; d >= 0; d--) if (m_own[d] == s) m_srx[s] = dst_rx_i[d];
      end
      m_rv = 0; m_re = 0;
      if (m_pend) begin
        if (safe_pt) begin
          m_rv = 1; m_pend = 0;
          if (m_ps >= N || m_pd >= N) m_re = 1;
          else if (m_op) begin
            if (m_own[m_pd] >= 0) m_re = 1; else m_own[m_pd] = m_ps;
          end else begin
            if (m_own[m_pd] != m_ps) m_re = 1; else m_own[m_pd] = -1;
          end
        end
      end else if (cmd_valid) begin
        m_pend = 1; m_op = cmd_op; m_ps = int'(cmd_src); m_pd = int'(cmd_dst);
      end
    end
    if (rst_n) begin
      rs2 = rs1; rs1 = 1;
    end
    if (compare_on) begin
      // R8 R10: forward lines, including untouched routes on an applying edge
      check(dst_tx_o == m_dtx, "R8 R10", "dst_tx_o", dst_tx_o, m_dtx);
      check(src_rx_o == m_srx, "R9", "src_rx_o", src_rx_o, m_srx);
      check(cmd_ready == !m_pend, "R2", "cmd_ready", cmd_ready, !m_pend);
      check(resp_valid == m_rv, "R3 R4", "resp_valid", resp_valid, m_rv);
      check(!m_rv || resp_err == m_re, "R5 R6 R7", "resp_err", resp_err, m_re);
      check(rd_owned == (m_own[rd_idx % N] >= 0) || rd_idx >= N, "R11", "rd_owned",
            rd_owned, m_own[rd_idx % N] >= 0);
    end
    if (resp_valid) begin
      got_resp = 1; got_err = resp_err;
    end
  end

  always @(negedge clk) begin
    src_tx_i <= N'($urandom);
    dst_rx_i <= N'($urandom);
  end

  task automatic run_cmd(input bit op, input int s, input int d, input bit exp_err,
                         input string tag, input int hold, input bit safe_at_cap);
    bit pre_own;
    logic [SW-1:0] pre_src;
    while (!cmd_ready) @(negedge clk);
    rd_idx = SW'(d);
    #1;
    pre_own = rd_owned; pre_src = rd_src;
    cmd_valid = 1; cmd_op = op; cmd_src = SW'(s); cmd_dst = SW'(d);
    safe_pt = safe_at_cap;
    got_resp = 0;
    @(negedge clk);
    cmd_valid = 0; safe_pt = 0;
    repeat (hold) @(negedge clk);
    // R3: nothing applied while safe_pt stayed low
    check(rd_owned == pre_own && rd_src == pre_src && !got_resp, "R3", "table before safe point",
          {rd_owned, rd_src}, {pre_own, pre_src});
    safe_pt = 1;
    @(negedge clk);
    safe_pt = 0;
    @(negedge clk);
    check(got_resp && got_err == exp_err, tag, "response error", got_err, exp_err);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_op = 0; cmd_src = 0; cmd_dst = 0;
    safe_pt = 0; rd_idx = 0; src_tx_i = 0; dst_rx_i = 0; compare_on = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(dst_tx_o == '1 && src_rx_o == '1, "R1", "idle lines", {dst_tx_o, src_rx_o}, 6'h3f);
    check(cmd_ready && !resp_valid && !rd_owned, "R1", "control after reset",
          {cmd_ready, resp_valid, rd_owned}, 3'b100);
    compare_on = 1;

    run_cmd(1, 0, 1, 0, "R4", 3, 0);   // connect 0->1
    run_cmd(1, 2, 1, 1, "R5", 1, 0);   // dst 1 taken
    run_cmd(1, 0, 2, 0, "R4", 2, 0);   // fan-out 0->2
    run_cmd(1, 1, 0, 0, "R3 R4", 0, 1); // safe point during capture
    run_cmd(0, 1, 2, 1, "R6", 1, 0);   // dst 2 owned by 0
    run_cmd(1, 3, 0, 1, "R7", 1, 0);   // bad source
    run_cmd(1, 0, 3, 1, "R7", 1, 0);   // bad destination
    repeat (20) @(negedge clk);
    run_cmd(0, 0, 1, 0, "R6 R10", 1, 0); // free dst 1, dst 2 stays live
    run_cmd(0, 0, 1, 1, "R6", 1, 0);   // already free
    repeat (10) @(negedge clk);

    // R11: readback of every destination
    rd_idx = 0; #1;
    check(rd_owned && rd_src == 1, "R11", "owner of dst0", {rd_owned, rd_src}, 3'b101);
    rd_idx = 1; #1;
    check(!rd_owned, "R11", "owner of dst1", rd_owned, 0);
    rd_idx = 2; #1;
    check(rd_owned && rd_src == 0, "R11", "owner of dst2", {rd_owned, rd_src}, 3'b100);
    @(negedge clk);
    // R8: freed destination idles high
    check(dst_tx_o[1] == 1'b1, "R8", "idle on dst1", dst_tx_o[1], 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule